// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the software-visible register file that sits in front of an I2C master bus engine. A 32-bit register port with separate read and write strobes gives software access to the control word, the target address, the enable and abort requests, an interrupt mask, raw and masked interrupt status, FIFO fill levels and a read-only capability word. The bus engine, whose serial timing and FIFO storage live elsewhere, receives the configuration as plain outputs. It reports back with event pulses, level inputs and an enable acknowledge.

Stop and abort events from the engine are held in sticky flags until software clears them. Software clears them by reading one of three clear locations. The TX-empty and RX-full indications follow live levels rather than being latched. One interrupt output is raised whenever any unmasked status bit is set. The enable status that software sees follows the engine's acknowledge, not the request, so the two can differ while the engine finishes a transfer. Control and target writes are locked out while the engine reports itself enabled.

Top module: `i2c_ru_top`

## Requirements
- R1: After reset, control, target, mask, enable and enable-status all read 0, raw status reads 0 with the engine levels at zero, and `irq` is low.
- R2: A write at offset 0x00 stores only bits 0, 1, 2, 5, 6 and 9, and the other bits read 0. A write at offset 0x04 stores bits 9:0 of the target address.
- R3: Writes to offsets 0x00 and 0x04 have no effect while the enable status is 1.
- R4: Bit 0 at offset 0x9C follows `eng_en_ack_i` with one register of delay and does not depend on the enable request at offset 0x6C.
- R5: At offset 0x6C, bit 0 is the enable request and bit 1 is the abort request. The abort bit is set only by a write that carries both bits at 1. It reads 1 until `abort_done_i` pulses and then reads 0. `abort_req_o` mirrors the abort bit.
- R6: Raw status at offset 0x34 has RX-full at bit 2 (level: RX level equals RX depth), TX-empty at bit 4 (level: TX level is 0 and enable status is 1), abort at bit 6 (sticky) and stop at bit 9 (sticky). All other bits read 0.
- R7: Offset 0x30 holds the mask, with only bits 2, 4, 6 and 9 writable. Offset 0x2C reads raw AND mask. `irq` is high exactly when that AND is non-zero.
- R8: A read of 0x40 clears both sticky flags and the abort source. A read of 0x54 clears only the abort flag and the abort source. A read of 0x60 clears only the stop flag. Each clear location reads 0.
- R9: An event pulse arriving in the same cycle as the read that clears its flag leaves the flag set.
- R10: Offset 0x80 accumulates `abort_cause_i` on each abort event, with bit 0 for an unacknowledged 7-bit address and bit 12 for lost arbitration, until the abort flag is cleared.
- R11: Offset 0xF4 reads max speed mode in bits 3:2, RX depth in bits 15:8 and TX depth in bits 23:16, all taken from parameters.
- R12: Offsets 0x74 and 0x78 read the TX and RX fill levels from the engine, zero-extended.
- R13: A write at 0x10 pulses `cmd_push_o` in the same cycle, with `cmd_word_o` equal to write data bits 9:0 (bit 8 read, bit 9 stop). A read at 0x10 pulses `rx_pop_o` and returns `rx_byte_i`.
- R14: Read data appears on `reg_rdata` in the cycle after the read strobe, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt, OR of masked status |
| ctrl_o | output | 10 | Control word to the engine |
| target_o | output | TAR_W | Target address to the engine |
| en_req_o | output | 1 | Enable request |
| abort_req_o | output | 1 | Abort request |
| cmd_push_o | output | 1 | Command write pulse |
| cmd_word_o | output | 10 | Command word (data, read flag, stop flag) |
| rx_pop_o | output | 1 | Receive byte pop pulse |
| rx_byte_i | input | 8 | Received byte at the head of the RX FIFO |
| tx_level_i | input | LVL_W | TX FIFO fill level |
| rx_level_i | input | LVL_W | RX FIFO fill level |
| eng_en_ack_i | input | 1 | Engine's actual enabled state |
| ev_abort_i | input | 1 | Transfer abort event pulse |
| abort_cause_i | input | SRC_W | Cause bits for the abort event |
| ev_stop_i | input | 1 | Stop condition event pulse |
| abort_done_i | input | 1 | Engine has completed a requested abort |

## Verification
The bench builds the block with TX depth 8, RX depth 4 and max speed mode 2. These values differ from the defaults, so every capability field is checked against a non-trivial value. A small RX level of 4 is enough to bring the RX-full level bit and its interrupt into play. The scoreboard follows the sticky flags through each clear location, and it covers the case where an event arrives in the same cycle as the clear read. It also checks the lag between the enable request and the acknowledged status, and the lockout of control writes that this lag causes.

// File: rtl/i2c_ru_pkg.sv
package i2c_ru_pkg;
  // register offsets (byte addresses)
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_TGT    = 'h04;
  localparam int OFS_DCMD   = 'h10;
  localparam int OFS_MSTAT  = 'h2C;
  localparam int OFS_MASK   = 'h30;
  localparam int OFS_RSTAT  = 'h34;
  localparam int OFS_CLRALL = 'h40;
  localparam int OFS_CLRABT = 'h54;
  localparam int OFS_CLRSTP = 'h60;
  localparam int OFS_EN     = 'h6C;
  localparam int OFS_TXLVL  = 'h74;
  localparam int OFS_RXLVL  = 'h78;
  localparam int OFS_ABTSRC = 'h80;
  localparam int OFS_ENSTAT = 'h9C;
  localparam int OFS_CAP    = 'hF4;

  // status bit positions
  localparam int IRQ_RXF = 2;
  localparam int IRQ_TXE = 4;
  localparam int IRQ_ABT = 6;
  localparam int IRQ_STP = 9;

  // enable register fields
  localparam int EN_BIT  = 0;
  localparam int ABT_BIT = 1;

  // writable bits of control and mask
  localparam logic [31:0] CTRL_KEEP = 32'h0000_0267;
  localparam logic [31:0] IRQ_KEEP  = (32'd1 << IRQ_RXF) | (32'd1 << IRQ_TXE) |
                                      (32'd1 << IRQ_ABT) | (32'd1 << IRQ_STP);

  // sticky event indices
  typedef enum int {EV_ABT = 0, EV_STP = 1, EV_NUM = 2} ev_idx_e;
endpackage

// File: rtl/i2c_ru_cfg.sv
module i2c_ru_cfg
  import i2c_ru_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              eng_en_ack,
  input  logic              abort_done,
  output logic [31:0]       ctrl_q,
  output logic [TAR_W-1:0]  tar_q,
  output logic [31:0]       mask_q,
  output logic              en_q,
  output logic              abt_q,
  output logic              en_stat_q
);
  logic [31:0]      ctrl_d, mask_d;
  logic [TAR_W-1:0] tar_d;
  logic             en_d, abt_d, en_stat_d;
  logic             wr_ctrl, wr_tgt, wr_mask, wr_en;

  assign wr_ctrl = wr && (addr == ADDR_W'(OFS_CTRL)) && !en_stat_q;
  assign wr_tgt  = wr && (addr == ADDR_W'(OFS_TGT))  && !en_stat_q;
  assign wr_mask = wr && (addr == ADDR_W'(OFS_MASK));
  assign wr_en   = wr && (addr == ADDR_W'(OFS_EN));

  always_comb begin
    ctrl_d    = ctrl_q;
    tar_d     = tar_q;
    mask_d    = mask_q;
    en_d      = en_q;
    abt_d     = abt_q;
    en_stat_d = eng_en_ack;
    if (wr_ctrl) ctrl_d = wdata & CTRL_KEEP;
    if (wr_tgt)  tar_d  = wdata[TAR_W-1:0];
    if (wr_mask) mask_d = wdata & IRQ_KEEP;
    if (abort_done) abt_d = 1'b0;
    if (wr_en) begin
      en_d  = wdata[EN_BIT];
      abt_d = wdata[EN_BIT] & wdata[ABT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tar_q     <= '0;
      mask_q    <= '0;
      en_q      <= 1'b0;
      abt_q     <= 1'b0;
      en_stat_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      tar_q     <= tar_d;
      mask_q    <= mask_d;
      en_q      <= en_d;
      abt_q     <= abt_d;
      en_stat_q <= en_stat_d;
    end
  end
endmodule

// File: rtl/i2c_ru_irq.sv
module i2c_ru_irq
  import i2c_ru_pkg::*;
#(
  parameter int SRC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_abort,
  input  logic             ev_stop,
  input  logic [SRC_W-1:0] abort_cause,
  input  logic             clr_abt,
  input  logic             clr_stp,
  input  logic             tx_empty_lvl,
  input  logic             rx_full_lvl,
  input  logic [31:0]      mask_q,
  output logic [31:0]      raw,
  output logic [31:0]      masked,
  output logic             irq,
  output logic [SRC_W-1:0] src_q
);
  localparam int NEV = EV_NUM;

  logic [NEV-1:0]   ev_v, clr_v, lat_q;
  logic [SRC_W-1:0] src_d;

  assign ev_v[EV_ABT]  = ev_abort;
  assign ev_v[EV_STP]  = ev_stop;
  assign clr_v[EV_ABT] = clr_abt;
  assign clr_v[EV_STP] = clr_stp;

  // one sticky flag per event; a new event beats a simultaneous clear
  for (genvar g = 0; g < NEV; g++) begin : g_lat
    logic q, d;
    assign d = (q & ~clr_v[g]) | ev_v[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign lat_q[g] = q;
  end

  assign src_d = (clr_abt ? '0 : src_q) | (ev_abort ? abort_cause : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  always_comb begin
    raw          = '0;
    raw[IRQ_RXF] = rx_full_lvl;
    raw[IRQ_TXE] = tx_empty_lvl;
    raw[IRQ_ABT] = lat_q[EV_ABT];
    raw[IRQ_STP] = lat_q[EV_STP];
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/i2c_ru_rdmux.sv
module i2c_ru_rdmux
  import i2c_ru_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int TAR_W     = 10,
  parameter int LVL_W     = 8,
  parameter int SRC_W     = 13,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter int MAX_SPEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       ctrl_q,
  input  logic [TAR_W-1:0]  tar_q,
  input  logic [31:0]       mask_q,
  input  logic [31:0]       raw,
  input  logic [31:0]       masked,
  input  logic              en_q,
  input  logic              abt_q,
  input  logic              en_stat_q,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [SRC_W-1:0]  src_q,
  input  logic [7:0]        rx_byte,
  output logic [31:0]       rdata_q
);
  localparam logic [31:0] CAP_WORD = ((32'(MAX_SPEED) & 32'h3)  << 2) |
                                     ((32'(RX_DEPTH)  & 32'hFF) << 8) |
                                     ((32'(TX_DEPTH)  & 32'hFF) << 16);

  logic [31:0] sel, rdata_d;

  always_comb begin
    sel = '0;
    case (addr)
      ADDR_W'(OFS_CTRL):   sel = ctrl_q;
      ADDR_W'(OFS_TGT):    sel = 32'(tar_q);
      ADDR_W'(OFS_DCMD):   sel = 32'(rx_byte);
      ADDR_W'(OFS_MSTAT):  sel = masked;
      ADDR_W'(OFS_MASK):   sel = mask_q;
      ADDR_W'(OFS_RSTAT):  sel = raw;
      ADDR_W'(OFS_EN):     sel = 32'({abt_q, en_q});
      ADDR_W'(OFS_TXLVL):  sel = 32'(tx_level);
      ADDR_W'(OFS_RXLVL):  sel = 32'(rx_level);
      ADDR_W'(OFS_ABTSRC): sel = 32'(src_q);
      ADDR_W'(OFS_ENSTAT): sel = 32'(en_stat_q);
      ADDR_W'(OFS_CAP):    sel = CAP_WORD;
      default:             sel = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) rdata_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/i2c_ru_top.sv
module i2c_ru_top
  import i2c_ru_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int TAR_W     = 10,
  parameter int LVL_W     = 8,
  parameter int SRC_W     = 13,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter int MAX_SPEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [9:0]        ctrl_o,
  output logic [TAR_W-1:0]  target_o,
  output logic              en_req_o,
  output logic              abort_req_o,
  output logic              cmd_push_o,
  output logic [9:0]        cmd_word_o,
  output logic              rx_pop_o,
  input  logic [7:0]        rx_byte_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              eng_en_ack_i,
  input  logic              ev_abort_i,
  input  logic [SRC_W-1:0]  abort_cause_i,
  input  logic              ev_stop_i,
  input  logic              abort_done_i
);
  logic [1:0]       rs_q;
  logic             rst_ni;
  logic [31:0]      ctrl_q, mask_q, raw, masked;
  logic [TAR_W-1:0] tar_q;
  logic [SRC_W-1:0] src_q;
  logic             en_q, abt_q, en_stat_q;
  logic             clr_abt, clr_stp, tx_empty_lvl, rx_full_lvl, en_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign clr_abt = reg_rd && ((reg_addr == ADDR_W'(OFS_CLRALL)) ||
                              (reg_addr == ADDR_W'(OFS_CLRABT)));
  assign clr_stp = reg_rd && ((reg_addr == ADDR_W'(OFS_CLRALL)) ||
                              (reg_addr == ADDR_W'(OFS_CLRSTP)));
  assign en_wr   = reg_wr && (reg_addr == ADDR_W'(OFS_EN));

  assign tx_empty_lvl = en_stat_q && (tx_level_i == '0);
  assign rx_full_lvl  = (rx_level_i == LVL_W'(RX_DEPTH));

  i2c_ru_cfg #(.ADDR_W(ADDR_W), .TAR_W(TAR_W)) u_cfg (
    .clk(clk), .rst_n(rst_ni), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .eng_en_ack(eng_en_ack_i), .abort_done(abort_done_i),
    .ctrl_q(ctrl_q), .tar_q(tar_q), .mask_q(mask_q), .en_q(en_q),
    .abt_q(abt_q), .en_stat_q(en_stat_q)
  );

  i2c_ru_irq #(.SRC_W(SRC_W)) u_irq (
    .clk(clk), .rst_n(rst_ni), .ev_abort(ev_abort_i), .ev_stop(ev_stop_i),
    .abort_cause(abort_cause_i), .clr_abt(clr_abt), .clr_stp(clr_stp),
    .tx_empty_lvl(tx_empty_lvl), .rx_full_lvl(rx_full_lvl), .mask_q(mask_q),
    .raw(raw), .masked(masked), .irq(irq), .src_q(src_q)
  );

  i2c_ru_rdmux #(
    .ADDR_W(ADDR_W), .TAR_W(TAR_W), .LVL_W(LVL_W), .SRC_W(SRC_W),
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .MAX_SPEED(MAX_SPEED)
  ) u_rd (
    .clk(clk), .rst_n(rst_ni), .rd(reg_rd), .addr(reg_addr),
    .ctrl_q(ctrl_q), .tar_q(tar_q), .mask_q(mask_q), .raw(raw), .masked(masked),
    .en_q(en_q), .abt_q(abt_q), .en_stat_q(en_stat_q),
    .tx_level(tx_level_i), .rx_level(rx_level_i), .src_q(src_q),
    .rx_byte(rx_byte_i), .rdata_q(reg_rdata)
  );

  assign ctrl_o      = ctrl_q[9:0];
  assign target_o    = tar_q;
  assign en_req_o    = en_q;
  assign abort_req_o = abt_q;
  assign cmd_push_o  = reg_wr && (reg_addr == ADDR_W'(OFS_DCMD));
  assign cmd_word_o  = reg_wdata[9:0];
  assign rx_pop_o    = reg_rd && (reg_addr == ADDR_W'(OFS_DCMD));
endmodule

// File: rtl/i2c_ru_chk.sv
module i2c_ru_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_req,
  input logic        abt_req,
  input logic        en_stat,
  input logic        en_wr,
  input logic        abort_done,
  input logic [31:0] ctrl,
  input logic [31:0] mask,
  input logic [31:0] raw,
  input logic        ev_stop,
  input logic        irq
);
  // R5
  abort_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abt_req |-> en_req);

  // R5
  abort_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_done && !en_wr) |=> !abt_req);

  // R3
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_stat |=> $stable(ctrl));

  // R9
  stop_event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> raw[9]);

  // R7
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 32'd0) |-> !irq);
endmodule

bind i2c_ru_top i2c_ru_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .en_req(en_req_o), .abt_req(abort_req_o),
  .en_stat(en_stat_q), .en_wr(en_wr), .abort_done(abort_done_i),
  .ctrl(ctrl_q), .mask(mask_q), .raw(raw), .ev_stop(ev_stop_i), .irq(irq)
);

// File: tb/sim_i2c_ru_top.sv
`timescale 1ns/1ps
module sim_i2c_ru_top;
  logic        clk, rst_n, reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, en_req_o, abort_req_o, cmd_push_o, rx_pop_o;
  logic [9:0]  ctrl_o, cmd_word_o, target_o;
  logic [7:0]  rx_byte_i, tx_level_i, rx_level_i;
  logic        eng_en_ack_i, ev_abort_i, ev_stop_i, abort_done_i;
  logic [12:0] abort_cause_i;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend;

  i2c_ru_top #(.TX_DEPTH(8), .RX_DEPTH(4), .MAX_SPEED(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .ctrl_o(ctrl_o), .target_o(target_o), .en_req_o(en_req_o),
    .abort_req_o(abort_req_o), .cmd_push_o(cmd_push_o), .cmd_word_o(cmd_word_o),
    .rx_pop_o(rx_pop_o), .rx_byte_i(rx_byte_i), .tx_level_i(tx_level_i),
    .rx_level_i(rx_level_i), .eng_en_ack_i(eng_en_ack_i), .ev_abort_i(ev_abort_i),
    .abort_cause_i(abort_cause_i), .ev_stop_i(ev_stop_i), .abort_done_i(abort_done_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one read result per strobe, compared a cycle later
  always @(posedge clk) pend <= reg_rd;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL scoreboard actual=%h expected=none", reg_rdata);
      end else begin
        chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); ev_stop_i = 1'b1;
    @(negedge clk); ev_stop_i = 1'b0;
  endtask

  task automatic pulse_abort(input logic [12:0] c);
    @(negedge clk); ev_abort_i = 1'b1; abort_cause_i = c;
    @(negedge clk); ev_abort_i = 1'b0; abort_cause_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_byte_i = '0; tx_level_i = '0; rx_level_i = '0; eng_en_ack_i = 1'b0;
    ev_abort_i = 1'b0; ev_stop_i = 1'b0; abort_done_i = 1'b0; abort_cause_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h6C, 32'h0, "R1 enable");
    rd(8'h9C, 32'h0, "R1 enstat");
    rd(8'h34, 32'h0, "R1 raw");
    #1 chk(irq, 1'b0, "R1 irq");

    // R2 writable bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h267, "R2 ctrl mask");
    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04, 32'h3FF, "R2 target");
    wr(8'h00, 32'h63);
    rd(8'h00, 32'h63, "R2 ctrl value");
    #1 chk(32'(ctrl_o), 32'h63, "R2 ctrl_o");

    // R11 capability, R12 levels, R14 unmapped
    rd(8'hF4, 32'h0008_0408, "R11 capability");
    tx_level_i = 8'd3; rx_level_i = 8'd2;
    rd(8'h74, 32'd3, "R12 tx level");
    rd(8'h78, 32'd2, "R12 rx level");
    rd(8'h08, 32'h0, "R14 unmapped");

    // R4 enable status lags the request
    wr(8'h6C, 32'h1);
    rd(8'h6C, 32'h1, "R4 enable req");
    rd(8'h9C, 32'h0, "R4 enstat before ack");
    @(negedge clk) eng_en_ack_i = 1'b1;
    rd(8'h9C, 32'h1, "R4 enstat after ack");

    // R3 lockout while enabled
    wr(8'h00, 32'h1);
    rd(8'h00, 32'h63, "R3 ctrl locked");
    wr(8'h04, 32'h55);
    rd(8'h04, 32'h3FF, "R3 target locked");

    // R6 level bits, R7 mask and irq
    tx_level_i = 8'd0; rx_level_i = 8'd4;
    rd(8'h34, 32'h14, "R6 raw levels");
    rd(8'h2C, 32'h0, "R7 masked zero");
    #1 chk(irq, 1'b0, "R7 irq masked off");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h254, "R7 mask bits");
    rd(8'h2C, 32'h14, "R7 masked");
    #1 chk(irq, 1'b1, "R7 irq on");
    wr(8'h30, 32'h200);
    #1 chk(irq, 1'b0, "R7 irq stop only");

    // R6 sticky stop, R10 abort source
    pulse_stop();
    #1 chk(irq, 1'b1, "R7 irq on stop");
    rd(8'h34, 32'h214, "R6 stop sticky");
    pulse_abort(13'h1001);
    rd(8'h34, 32'h254, "R6 abort sticky");
    rd(8'h80, 32'h1001, "R10 abort source");

    // R8 selective clears
    rd(8'h60, 32'h0, "R8 clr stop read");
    rd(8'h34, 32'h54, "R8 stop cleared only");
    rd(8'h80, 32'h1001, "R8 source kept");
    #1 chk(irq, 1'b0, "R8 irq after clear");
    rd(8'h54, 32'h0, "R8 clr abort read");
    rd(8'h34, 32'h14, "R8 abort cleared");
    rd(8'h80, 32'h0, "R8 source cleared");
    pulse_stop();
    pulse_abort(13'h0001);
    rd(8'h40, 32'h0, "R8 clr all read");
    rd(8'h34, 32'h14, "R8 all cleared");
    rd(8'h80, 32'h0, "R8 all source");

    // R9 event in the same cycle as its clear
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h60; ev_stop_i = 1'b1;
    exp_q.push_back(32'h0); tag_q.push_back("R9 clr read");
    @(negedge clk); reg_rd = 1'b0; ev_stop_i = 1'b0;
    rd(8'h34, 32'h214, "R9 stop kept");
    rd(8'h40, 32'h0, "R9 clr all");

    // R5 abort request handling
    wr(8'h6C, 32'h2);
    rd(8'h6C, 32'h0, "R5 abort refused");
    rd(8'h9C, 32'h1, "R4 enstat still 1");
    wr(8'h6C, 32'h3);
    rd(8'h6C, 32'h3, "R5 abort set");
    #1 chk(abort_req_o, 1'b1, "R5 abort_req_o");
    @(negedge clk) abort_done_i = 1'b1;
    @(negedge clk) abort_done_i = 1'b0;
    rd(8'h6C, 32'h1, "R5 abort self clear");
    #1 chk(abort_req_o, 1'b0, "R5 abort_req_o low");

    // R13 command and receive path
    @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h300;
    #1 chk(cmd_push_o, 1'b1, "R13 cmd push");
    chk(32'(cmd_word_o), 32'h300, "R13 cmd word");
    @(negedge clk); reg_wr = 1'b0;
    #1 chk(cmd_push_o, 1'b0, "R13 cmd push end");
    rx_byte_i = 8'hA5;
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h10;
    exp_q.push_back(32'hA5); tag_q.push_back("R13 rx byte");
    #1 chk(rx_pop_o, 1'b1, "R13 rx pop");
    @(negedge clk); reg_rd = 1'b0;

    // R6 tx-empty drops with enable status
    @(negedge clk) eng_en_ack_i = 1'b0;
    rd(8'h34, 32'h04, "R6 tx empty gated");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++; nerr++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule